// File: doc/BRIEF.md
# Stall and Flush Controller for a Forwarding-Free Five-Stage Pipeline

This block decides each cycle whether a small in-order integer pipeline may advance. The pipeline has no operand forwarding. A decoded instruction that reads a register still owed by an older instruction in execute or memory must therefore wait in decode. Once that producer reaches writeback the consumer may leave, because the register file writes in the first half of the cycle. Subtract occupies execute for several cycles, three by default. During those cycles fetch, decode and execute all hold. A taken conditional branch, resolved in execute, discards the two younger instructions and redirects fetch.

The controller observes only register fields, validity bits and a 3-bit class code for the instructions in decode, execute and memory, together with the branch outcome. It drives hold enables for fetch and decode, a hold for execute, a bubble insert into execute and a flush. It also keeps the fetch program counter, which starts at address 0 after reset. A flush always wins over a stall in the same cycle.

The subtract sequencer is a two-state machine. In state SQ_IDLE, a subtract present in execute asserts the hold and takes the transition "sub arrives" to SQ_BUSY. In SQ_BUSY the hold stays asserted until the internal count reaches the last cycle. At that point the hold drops and the transition "sub completes" returns the machine to SQ_IDLE.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While reset is held and for the first cycle after it, `fetch_pc` is 0. With idle inputs, `if_hold`, `id_hold`, `ex_bubble`, `ex_hold` and `flush` are all 0.
- R2: An instruction in decode depends on a producer when all of the following are true: `id_valid` is 1, a source it uses equals the `rd` of a valid producer in execute or memory, and that source is not register 0. In that case `if_hold`, `id_hold` and `ex_bubble` are 1, provided no flush or subtract hold applies.
- R3: Register 0 never causes a stall, either as a source or as a destination.
- R4: Class codes are 0 ALU, 1 load, 2 store, 3 branch and 4 subtract. Classes 0, 1 and 4 are producers. Store and branch never cause a stall.
- R5: When a subtract (class 4) is valid in execute, `ex_hold`, `if_hold` and `id_hold` are 1 for the first SUB_CYCLES-1 cycles and 0 in the last cycle, while `ex_bubble` stays 0. Another subtract entering afterwards starts a new hold.
- R6: Valid instructions of any other class in execute never assert `ex_hold`.
- R7: A valid branch (class 3) in execute with `br_taken`=1 asserts `flush` and `ex_bubble`. With `br_taken`=0 there is no flush.
- R8: When a flush and a dependency stall occur in the same cycle, `if_hold` and `id_hold` are 0.
- R9: `fetch_pc` advances by 4 on each edge without hold or flush, and stays unchanged while `if_hold` is 1. On a flush it becomes `br_pc`+4+4×`br_offset`, where the offset is sign-extended.
- R10: A source whose use flag is 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | 4 | First source register of decode instruction |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | 4 | Second source register of decode instruction |
| id_rs2_used | input | 1 | Second source is read |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_class | input | 3 | Class code of execute instruction |
| ex_rd | input | 4 | Destination register in execute |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_class | input | 3 | Class code of memory instruction |
| mem_rd | input | 4 | Destination register in memory |
| br_taken | input | 1 | Branch in execute resolved taken |
| br_pc | input | 32 | Address of the branch in execute |
| br_offset | input | 16 | Signed word offset of that branch |
| if_hold | output | 1 | Freeze fetch |
| id_hold | output | 1 | Freeze decode |
| ex_bubble | output | 1 | Load a bubble into execute |
| ex_hold | output | 1 | Keep the execute instruction in place |
| flush | output | 1 | Discard fetch and decode contents |
| fetch_pc | output | 32 | Current fetch address |

## Verification
On every cycle, assertions check four things. A subtract hold only appears while a subtract is in execute, and it lasts past its first cycle. The fetch address is frozen under a stall. Register 0 and unused sources never trigger a dependency. Any bubble outside a flush has a decode instruction behind it. Only the bench's scenarios can show the rest. These are the full comparator matrix over every register pair and class in both producer stages, the exact release cycle of a subtract, the redirect arithmetic with negative and positive offsets, and the resolution between a flush and a stall.

// File: rtl/stall_ctrl_pkg.sv
package stall_ctrl_pkg;
    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_SUB    = 3'd4
    } instr_class_e;

    function automatic logic writes_reg(input logic [2:0] cls);
        return (cls == CLS_ALU) || (cls == CLS_LOAD) || (cls == CLS_SUB);
    endfunction
endpackage

// File: rtl/raw_detect.sv
module raw_detect #(
    parameter int IDX_W    = 4,
    parameter int NUM_SRC  = 2,
    parameter int NUM_PROD = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cons_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0]  src_idx,
    input  logic [NUM_SRC-1:0]             src_used,
    input  logic [NUM_PROD-1:0]            prod_valid,
    input  logic [NUM_PROD-1:0][2:0]       prod_class,
    input  logic [NUM_PROD-1:0][IDX_W-1:0] prod_rd,
    output logic                           raw
);
    import stall_ctrl_pkg::*;

    logic [NUM_SRC-1:0][NUM_PROD-1:0] hit;
    logic [NUM_SRC-1:0]               src_live;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_live[s] = src_used[s] && (src_idx[s] != '0);
        for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
            assign hit[s][p] = src_live[s] && prod_valid[p]
                             && writes_reg(prod_class[p])
                             && (prod_rd[p] == src_idx[s]);
        end
    end

    assign raw = cons_valid && (|hit);

    // R3 / R10: register 0 and unread sources are never hazard sources
    p_zero_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!src_used[0] || src_idx[0] == '0) && (!src_used[NUM_SRC-1] || src_idx[NUM_SRC-1] == '0))
        |-> !raw);
endmodule

// File: rtl/sub_sequencer.sv
module sub_sequencer #(
    parameter int SUB_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ex_valid,
    input  logic ex_is_sub,
    output logic busy
);
    localparam int          CW   = $clog2(SUB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SUB_CYCLES - 1);
    localparam bit          LONG = (SUB_CYCLES > 1);

    typedef enum logic {SQ_IDLE, SQ_BUSY} sq_state_e;

    sq_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sub_arrives;

    assign sub_arrives = ex_valid && ex_is_sub && LONG;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_IDLE: if (sub_arrives) begin
                state_d = SQ_BUSY;
                cnt_d   = CW'(1);
            end
            SQ_BUSY: if (cnt_q == LAST) begin
                state_d = SQ_IDLE;
                cnt_d   = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SQ_IDLE: busy = sub_arrives;
            SQ_BUSY: busy = (cnt_q != LAST);
            default: busy = 1'b0;
        endcase
    end

    p_hold_needs_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ex_valid && ex_is_sub));
    p_hold_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((SUB_CYCLES > 2) && $rose(busy)) |=> busy);
endmodule

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             redirect,
    input  logic [PC_W-1:0]  br_pc,
    input  logic [OFF_W-1:0] br_offset,
    output logic [PC_W-1:0]  pc
);
    localparam int EXT_W = PC_W - OFF_W - 2;

    logic [PC_W-1:0] byte_off;
    logic [PC_W-1:0] pc_d;

    assign byte_off = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 2'b00};

    always_comb begin
        if (redirect)   pc_d = br_pc + PC_W'(4) + byte_off;
        else if (stall) pc_d = pc;
        else            pc_d = pc + PC_W'(4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_d;
    end

    p_pc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> $stable(pc));
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl #(
    parameter int NUM_REGS   = 10,
    parameter int SUB_CYCLES = 3,
    parameter int PC_W       = 32,
    parameter int OFF_W      = 16,
    parameter int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [IDX_W-1:0] id_rs1,
    input  logic             id_rs1_used,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_rs2_used,
    input  logic             ex_valid,
    input  logic [2:0]       ex_class,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             mem_valid,
    input  logic [2:0]       mem_class,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_pc,
    input  logic [OFF_W-1:0] br_offset,
    output logic             if_hold,
    output logic             id_hold,
    output logic             ex_bubble,
    output logic             ex_hold,
    output logic             flush,
    output logic [PC_W-1:0]  fetch_pc
);
    import stall_ctrl_pkg::*;

    localparam int NSRC  = 2;
    localparam int NPROD = 2;

    logic raw, sub_busy, stall_any;

    raw_detect #(.IDX_W(IDX_W), .NUM_SRC(NSRC), .NUM_PROD(NPROD)) u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .cons_valid (id_valid),
        .src_idx    ({id_rs2, id_rs1}),
        .src_used   ({id_rs2_used, id_rs1_used}),
        .prod_valid ({mem_valid, ex_valid}),
        .prod_class ({mem_class, ex_class}),
        .prod_rd    ({mem_rd, ex_rd}),
        .raw        (raw)
    );

    sub_sequencer #(.SUB_CYCLES(SUB_CYCLES)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_valid  (ex_valid),
        .ex_is_sub (ex_class == CLS_SUB),
        .busy      (sub_busy)
    );

    assign flush     = ex_valid && (ex_class == CLS_BRANCH) && br_taken;
    assign stall_any = raw || sub_busy;
    assign if_hold   = stall_any && !flush;
    assign id_hold   = stall_any && !flush;
    assign ex_hold   = sub_busy;
    assign ex_bubble = flush || (raw && !sub_busy);

    fetch_pc_gen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall_any),
        .redirect  (flush),
        .br_pc     (br_pc),
        .br_offset (br_offset),
        .pc        (fetch_pc)
    );

    p_bubble_has_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_bubble && !flush) |-> id_valid);
endmodule

// File: tb/pipe_stall_ctrl_tb_top.sv
module pipe_stall_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SUB_LAT    = 3;

    logic        clk = 0, rst_n = 0;
    logic        id_valid = 0, id_rs1_used = 0, id_rs2_used = 0;
    logic [3:0]  id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
    logic        ex_valid = 0, mem_valid = 0, br_taken = 0;
    logic [2:0]  ex_class = 0, mem_class = 0;
    logic [31:0] br_pc = 0;
    logic [15:0] br_offset = 0;
    logic        if_hold, id_hold, ex_bubble, ex_hold, flush;
    logic [31:0] fetch_pc;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_stall_ctrl dut_i (.*);

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit prod(logic [2:0] c);
        return c == 3'd0 || c == 3'd1 || c == 3'd4;
    endfunction

    function automatic bit exp_raw();
        bit h = 0;
        if (id_rs1_used && id_rs1 != 0)
            h |= (ex_valid && prod(ex_class) && ex_rd == id_rs1) || (mem_valid && prod(mem_class) && mem_rd == id_rs1);
        if (id_rs2_used && id_rs2 != 0)
            h |= (ex_valid && prod(ex_class) && ex_rd == id_rs2) || (mem_valid && prod(mem_class) && mem_rd == id_rs2);
        return id_valid && h;
    endfunction

    task automatic idle();
        id_valid = 0; id_rs1_used = 0; id_rs2_used = 0; ex_valid = 0;
        mem_valid = 0; br_taken = 0; ex_class = 0; mem_class = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] p0;
        repeat (2) @(negedge clk);
        chk("R1", "pc in reset", fetch_pc, 0);
        chk("R1", "if_hold", if_hold, 0);
        chk("R1", "ex_bubble", ex_bubble, 0);
        chk("R1", "ex_hold", ex_hold, 0);
        chk("R1", "flush", flush, 0);
        rst_n = 1;
        #1 chk("R1", "pc after reset", fetch_pc, 0);

        // R2/R3/R4: decode src1 against every EX destination and non-sub class
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 10; r++)
                for (int d = 0; d < 10; d++) begin
                    @(negedge clk); idle();
                    id_valid = 1; id_rs1 = 4'(r); id_rs1_used = 1;
                    ex_valid = 1; ex_class = 3'(c); ex_rd = 4'(d);
                    #1;
                    chk("R2_R3_R4", "ex_bubble ex", ex_bubble, exp_raw());
                    chk("R2", "if_hold ex", if_hold, exp_raw());
                    chk("R2", "id_hold ex", id_hold, exp_raw());
                end
        // src2 against every MEM destination and class including subtract
        for (int c = 0; c < 5; c++)
            for (int r = 0; r < 10; r++)
                for (int d = 0; d < 10; d++) begin
                    @(negedge clk); idle();
                    id_valid = 1; id_rs2 = 4'(r); id_rs2_used = 1;
                    mem_valid = 1; mem_class = 3'(c); mem_rd = 4'(d);
                    #1;
                    chk("R2_R3_R4", "ex_bubble mem", ex_bubble, exp_raw());
                end
        // R10: matching sources but unused
        @(negedge clk); idle();
        id_valid = 1; id_rs1 = 5; id_rs2 = 5; ex_valid = 1; ex_rd = 5;
        mem_valid = 1; mem_rd = 5;
        #1 chk("R10", "unused src stall", ex_bubble, 0);
        // id_valid low: no stall
        id_rs1_used = 1; id_valid = 0;
        #1 chk("R2", "no consumer", if_hold, 0);

        // R9: advance, hold, redirect
        @(negedge clk); idle(); p0 = fetch_pc;
        @(negedge clk); chk("R9", "pc +4", fetch_pc, p0 + 4);
        id_valid = 1; id_rs1 = 7; id_rs1_used = 1; ex_valid = 1; ex_rd = 7;
        p0 = fetch_pc;
        @(negedge clk); chk("R9", "pc held", fetch_pc, p0);
        idle(); ex_valid = 1; ex_class = 3; br_taken = 1;
        br_pc = 32'h100; br_offset = 16'hFFFD;
        #1 chk("R7", "flush taken", flush, 1);
        chk("R7", "bubble on flush", ex_bubble, 1);
        @(negedge clk); chk("R9", "pc redirect neg", fetch_pc, 32'hF8);
        br_pc = 32'h200; br_offset = 16'd5;
        @(negedge clk); chk("R9", "pc redirect pos", fetch_pc, 32'h218);
        br_taken = 0;
        #1 chk("R7", "no flush untaken", flush, 0);

        // R8: flush over stall
        id_valid = 1; id_rs1 = 3; id_rs1_used = 1; mem_valid = 1; mem_rd = 3;
        #1 chk("R8", "stall untaken", if_hold, 1);
        br_taken = 1;
        #1 chk("R8", "if_hold under flush", if_hold, 0);
        chk("R8", "id_hold under flush", id_hold, 0);
        chk("R8", "flush", flush, 1);

        // R5: subtract occupies execute SUB_LAT cycles
        @(negedge clk); idle(); @(negedge clk);
        id_valid = 1; id_rs1 = 9; id_rs1_used = 1; mem_valid = 1; mem_rd = 9;
        ex_valid = 1; ex_class = 4; ex_rd = 2;
        p0 = fetch_pc;
        for (int k = 0; k < SUB_LAT; k++) begin
            #1;
            chk("R5", "ex_hold", ex_hold, k < SUB_LAT - 1);
            chk("R5", "ex_bubble", ex_bubble, k < SUB_LAT - 1 ? 0 : 1);
            chk("R5", "if_hold", if_hold, 1);
            chk("R9", "pc during sub", fetch_pc, p0);
            @(negedge clk);
        end
        mem_valid = 0;
        #1 chk("R5", "second sub holds", ex_hold, 1);
        @(negedge clk);
        @(negedge clk);
        // R6: other classes never hold execute
        for (int c = 0; c < 4; c++) begin
            ex_class = 3'(c); br_taken = 0;
            #1 chk("R6", "no ex_hold", ex_hold, 0);
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule